// File: doc/BRIEF.md
# Configurable Registered Command/Address Buffer

This block registers the command and address lines of a memory module on the rising clock edge and drives them to the memory devices. It runs in one of two modes, chosen by a configuration input. In the wide mode, every one of 24 lanes plus a chip-select bit is registered once, with one output per input. In the duplicated mode, only the 13 primary lanes plus the chip-select bit are registered, and each registered bit drives two output banks, A and B. In duplicated mode a second configuration input moves the clock-enable and on-die-termination lanes between two positions. The input vector is indexed by lane, and lane positions follow the physical pin order.

Two chip-select inputs together decide whether the ordinary data lanes update. When both are high at a clock edge, the data lanes keep their previous values. The clock-enable lane, the on-die-termination lane and the registered chip-select update on every edge. An active-low reset clears every output at once, without waiting for a clock edge. Reset is released through a synchronizer. The mode inputs are captured only while reset is held, so a mode change needs a reset pulse.

Top module: `cmdreg_top`

## Requirements
- R1: While `rst_n` is low, `qa`, `qb`, `qcs_a` and `qcs_b` are all zero, and they reach zero as soon as `rst_n` falls, without waiting for a clock edge.
- R2: In wide mode (`cfg_dup`=0 captured at reset), each `qa[i]` for i in 0..23 loads `din[i]` at a clock edge where gating is off, and `qb` and `qcs_b` stay zero.
- R3: In duplicated mode (`cfg_dup`=1), `qa[12:0]` loads `din[12:0]`, `qb` equals `qa[12:0]`, and `qa[23:13]` stays zero whatever `din[23:13]` holds.
- R4: At an edge where `cs_dev` and `cs_rank` are both 1, every ordinary data lane of `qa` (and `qb`) keeps its previous value. If either input is 0, the data lanes load.
- R5: The control lanes load `din` on every edge, regardless of gating. In wide mode, and in duplicated mode with `cfg_alt`=0, the control lanes are lane 0 (clock enable) and lane 3 (termination). In duplicated mode with `cfg_alt`=1, they are lane 12 (clock enable) and lane 9 (termination), and lanes 0 and 3 become ordinary gated data lanes.
- R6: `qcs_a` loads `cs_dev` on every edge, regardless of gating. `qcs_b` equals `qcs_a` in duplicated mode and is zero in wide mode.
- R7: `cfg_dup` and `cfg_alt` are sampled only on clock edges while reset is held. A change to either input after reset release has no effect on the outputs.
- R8: After `rst_n` rises, the outputs stay zero through the next two rising edges, and the third rising edge is the first one that loads data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| cfg_dup | input | 1 | 1 selects 13-lane duplicated mode, 0 selects 24-lane wide mode |
| cfg_alt | input | 1 | In duplicated mode, 1 selects the alternate control-lane positions |
| cs_dev | input | 1 | Device chip select; registered onto `qcs_a`/`qcs_b` and part of the gating pair |
| cs_rank | input | 1 | Second gating chip select |
| din | input | 24 | Lane inputs, lanes 0..12 primary, 13..23 wide-mode only |
| qa | output | 24 | Bank A registered lanes |
| qb | output | 13 | Bank B copy of primary lanes (duplicated mode only) |
| qcs_a | output | 1 | Registered chip select, bank A |
| qcs_b | output | 1 | Registered chip select, bank B (duplicated mode only) |

## Verification
The bench builds the block with its defaults: 13 primary lanes, 11 secondary lanes and a two-stage reset release. With these values, the two control-lane layouts (lanes 0/3 and lanes 12/9) do not overlap. The bench can therefore show that lanes 0 and 3 are gated in the alternate layout and free in the standard one. The 11 secondary lanes give the wide and duplicated modes a visible difference. The two-stage release gives a fixed three-edge start-up that the bench counts exactly.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

  typedef struct packed {
    logic dup;
    logic alt;
  } cmdreg_mode_t;

  // control lane positions: standard layout counts from the bottom,
  // alternate layout counts from the top of the primary lanes
  localparam int CKE_STD      = 0;
  localparam int ODT_STD      = 3;
  localparam int CKE_ALT_TOP  = 1;
  localparam int ODT_ALT_TOP  = 4;

  function automatic logic is_ctrl_lane(input int lane, input int pri, input cmdreg_mode_t m);
    if (m.dup && m.alt)
      return (lane == pri - CKE_ALT_TOP) || (lane == pri - ODT_ALT_TOP);
    return (lane == CKE_STD) || (lane == ODT_STD);
  endfunction

endpackage

// File: rtl/cmdreg_rst_sync.sv
module cmdreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/cmdreg_lane_map.sv
module cmdreg_lane_map
  import cmdreg_pkg::*;
#(
  parameter int PRI = 13,
  parameter int SEC = 11,
  localparam int TOT = PRI + SEC
) (
  input  cmdreg_mode_t   mode,
  output logic [TOT-1:0] use_mask,
  output logic [TOT-1:0] ctrl_mask
);
  for (genvar g = 0; g < TOT; g++) begin : g_lane
    if (g < PRI) begin : g_pri
      assign use_mask[g]  = 1'b1;
      assign ctrl_mask[g] = is_ctrl_lane(g, PRI, mode);
    end else begin : g_sec
      assign use_mask[g]  = ~mode.dup;
      assign ctrl_mask[g] = 1'b0;
    end
  end
endmodule

// File: rtl/cmdreg_bank.sv
module cmdreg_bank #(
  parameter int TOT = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TOT-1:0] use_mask,
  input  logic [TOT-1:0] ctrl_mask,
  input  logic           hold,
  input  logic [TOT-1:0] d,
  input  logic           cs_in,
  output logic [TOT-1:0] q,
  output logic           q_cs
);
  for (genvar g = 0; g < TOT; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      q[g] <= 1'b0;
      else if (!use_mask[g])           q[g] <= 1'b0;
      else if (ctrl_mask[g] || !hold)  q[g] <= d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_cs <= 1'b0;
    else        q_cs <= cs_in;
  end
endmodule

// File: rtl/cmdreg_top.sv
module cmdreg_top
  import cmdreg_pkg::*;
#(
  parameter int PRI_LANES   = 13,
  parameter int SEC_LANES   = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_dup,
  input  logic                           cfg_alt,
  input  logic                           cs_dev,
  input  logic                           cs_rank,
  input  logic [PRI_LANES+SEC_LANES-1:0] din,
  output logic [PRI_LANES+SEC_LANES-1:0] qa,
  output logic [PRI_LANES-1:0]           qb,
  output logic                           qcs_a,
  output logic                           qcs_b
);
  localparam int TOT = PRI_LANES + SEC_LANES;

  logic           rst_int;
  cmdreg_mode_t   mode_q;
  logic [TOT-1:0] use_mask;
  logic [TOT-1:0] ctrl_mask;
  logic [TOT-1:0] bank_q;
  logic           bank_cs;

  cmdreg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int)
  );

  // mode follows the pins only while the block is held in reset
  always_ff @(posedge clk) begin
    if (!rst_int) begin
      mode_q.dup <= cfg_dup;
      mode_q.alt <= cfg_alt;
    end
  end

  cmdreg_lane_map #(.PRI(PRI_LANES), .SEC(SEC_LANES)) u_map (
    .mode      (mode_q),
    .use_mask  (use_mask),
    .ctrl_mask (ctrl_mask)
  );

  cmdreg_bank #(.TOT(TOT)) u_bank (
    .clk       (clk),
    .rst_n     (rst_int),
    .use_mask  (use_mask),
    .ctrl_mask (ctrl_mask),
    .hold      (cs_dev & cs_rank),
    .d         (din),
    .cs_in     (cs_dev),
    .q         (bank_q),
    .q_cs      (bank_cs)
  );

  assign qa    = bank_q;
  assign qb    = mode_q.dup ? bank_q[PRI_LANES-1:0] : '0;
  assign qcs_a = bank_cs;
  assign qcs_b = mode_q.dup ? bank_cs : 1'b0;
endmodule

// File: rtl/cmdreg_checker.sv
module cmdreg_checker #(
  parameter int PRI = 13,
  parameter int SEC = 11,
  localparam int TOT = PRI + SEC
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rst_int,
  input logic           mode_dup,
  input logic           mode_alt,
  input logic           cs_dev,
  input logic           cs_rank,
  input logic           din0,
  input logic [TOT-1:0] qa,
  input logic [PRI-1:0] qb,
  input logic           qcs_a,
  input logic           qcs_b
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |-> (qa == '0 && qb == '0 && !qcs_a && !qcs_b));

  // R2
  a_r2_wide_bank_b_idle: assert property (@(posedge clk) disable iff (!rst_int)
    !mode_dup |-> (qb == '0 && !qcs_b));

  // R3
  a_r3_dup_banks_match: assert property (@(posedge clk) disable iff (!rst_int)
    mode_dup |-> (qb == qa[PRI-1:0] && qa[TOT-1:PRI] == '0));

  // R4: lane 1 is a data lane in every layout
  a_r4_gate_holds_data: assert property (@(posedge clk) disable iff (!rst_int)
    ($past(rst_int) && $past(cs_dev && cs_rank)) |-> $stable(qa[1]));

  // R5
  a_r5_cke_lane_free: assert property (@(posedge clk) disable iff (!rst_int)
    ($past(rst_int) && !(mode_dup && mode_alt)) |-> (qa[0] == $past(din0)));

  // R6
  a_r6_cs_follows: assert property (@(posedge clk) disable iff (!rst_int)
    $past(rst_int) |-> (qcs_a == $past(cs_dev)));
endmodule

bind cmdreg_top cmdreg_checker #(.PRI(PRI_LANES), .SEC(SEC_LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_int  (rst_int),
  .mode_dup (mode_q.dup),
  .mode_alt (mode_q.alt),
  .cs_dev   (cs_dev),
  .cs_rank  (cs_rank),
  .din0     (din[0]),
  .qa       (qa),
  .qb       (qb),
  .qcs_a    (qcs_a),
  .qcs_b    (qcs_b)
);

// File: tb/cmdreg_top_test.sv
module cmdreg_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int PRI = 13;
  localparam int SEC = 11;
  localparam int TOT = PRI + SEC;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic           rst_n, cfg_dup, cfg_alt, cs_dev, cs_rank;
  logic [TOT-1:0] din;
  logic [TOT-1:0] qa;
  logic [PRI-1:0] qb;
  logic           qcs_a, qcs_b;

  cmdreg_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_dup(cfg_dup), .cfg_alt(cfg_alt),
    .cs_dev(cs_dev), .cs_rank(cs_rank), .din(din),
    .qa(qa), .qb(qb), .qcs_a(qcs_a), .qcs_b(qcs_b)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [TOT-1:0] m_qa;
  logic m_qcs, m_dup, m_alt;
  int rel_cnt;

  function automatic logic ctrl_lane(int i, logic dup, logic alt);
    if (dup && alt) return (i == 12) || (i == 9);
    return (i == 0) || (i == 3);
  endfunction

  function automatic logic [TOT-1:0] next_qa(logic [TOT-1:0] old, logic [TOT-1:0] d,
                                             logic dev, logic rank, logic dup, logic alt);
    logic [TOT-1:0] r;
    for (int i = 0; i < TOT; i++) begin
      if (dup && i >= PRI)                      r[i] = 1'b0;
      else if (ctrl_lane(i, dup, alt) || !(dev && rank)) r[i] = d[i];
      else                                      r[i] = old[i];
    end
    return r;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "qa", 32'(qa), 32'(m_qa));
    chk(m_dup ? "R3" : "R2", "qb", 32'(qb), m_dup ? 32'(m_qa[PRI-1:0]) : 32'd0);
    chk("R6", "qcs_a", 32'(qcs_a), 32'(m_qcs));
    chk("R6", "qcs_b", 32'(qcs_b), m_dup ? 32'(m_qcs) : 32'd0);
  endtask

  task automatic step(logic [TOT-1:0] d, logic dev, logic rank, string tag);
    din = d; cs_dev = dev; cs_rank = rank;
    @(posedge clk);
    if (rel_cnt >= 2) begin
      m_qa  = next_qa(m_qa, d, dev, rank, m_dup, m_alt);
      m_qcs = dev;
    end
    rel_cnt++;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic do_reset(logic dup, logic alt);
    @(negedge clk);
    cfg_dup = dup; cfg_alt = alt;
    rst_n = 1'b0;
    #1;
    chk("R1", "all outputs in reset",
        {6'd0, qa | {11'd0, qb}, qcs_a, qcs_b}, 32'd0);
    m_qa = '0; m_qcs = 1'b0; m_dup = dup; m_alt = alt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rel_cnt = 0;
  endtask

  task automatic rand_run(int n);
    for (int k = 0; k < n; k++) begin
      logic [TOT-1:0] d;
      logic dev, rank;
      d    = TOT'($urandom);
      dev  = ($urandom % 3) != 0;
      rank = ($urandom % 3) != 0;
      step(d, dev, rank, (dev && rank) ? "R4" : (m_dup ? "R3" : "R2"));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 1'b1; cfg_dup = 1'b0; cfg_alt = 1'b0;
    cs_dev = 1'b0; cs_rank = 1'b0; din = '0;
    #2 rst_n = 1'b0;

    // wide mode, release latency (R8)
    do_reset(1'b0, 1'b0);
    step('1, 1'b0, 1'b0, "R8");
    step('1, 1'b0, 1'b0, "R8");
    step('1, 1'b1, 1'b0, "R8");
    rand_run(200);
    // R5 standard layout: lanes 0 and 3 pass through gating
    step('0, 1'b0, 1'b0, "R2");
    step('1, 1'b1, 1'b1, "R5");
    step('0, 1'b1, 1'b1, "R4");

    // R1 with outputs non-zero, then duplicated standard layout
    step('1, 1'b1, 1'b0, "R2");
    do_reset(1'b1, 1'b0);
    rand_run(200);
    step('1, 1'b0, 1'b1, "R3");

    // duplicated alternate layout
    do_reset(1'b1, 1'b1);
    rand_run(3);
    step('0, 1'b0, 1'b0, "R3");
    step('1, 1'b1, 1'b1, "R5");
    rand_run(200);

    // R7: pins change after release, mode must stay
    cfg_dup = 1'b0; cfg_alt = 1'b0;
    step('0, 1'b0, 1'b0, "R7");
    step('1, 1'b1, 1'b1, "R7");
    step('1, 1'b0, 1'b1, "R7");
    rand_run(20);

    finish_run();
  end
endmodule